// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block drives the erase of an on-chip flash array one block at a time. A start request carries a block-select mask and an erase pulse length in clock cycles. The mask must select exactly one block; any other mask is refused at once with a bad-select status. An accepted request goes straight into an erase pass, with no pre-write of zeros. During the pass the erase enable is held high for the programmed number of cycles, and an independent watchdog ends the operation if that enable would stay high for longer than about 19.8 ms.

After each erase pulse the sequencer checks the block. For every longword, it first makes a dummy byte write of 8'hFF to a word-aligned address, then reads the 32-bit word back from that same address. Verify addresses start at the block base and step by 4. If any word reads other than all ones, a new erase pass begins. The block counts as erased once every word reads 32'hFFFFFFFF. A fixed pass limit, 100 by default, bounds the retries. To erase several blocks, software issues one start per block.

While an operation runs, an interrupt-mask output holds off every interrupt source, the non-maskable one included. When the operation ends, a one-cycle done pulse is raised and a status code is left in place until the next start. NUM_BLOCKS and BLOCK_WORDS must be powers of two and at least 2. The byte address is made up of the block index, the word offset and two zero bits.

Top module: `ferase_seq`

## Requirements
- R1: A start seen while idle with a mask whose popcount is not 1 (none or several bits set) is refused. In the next cycle done is 1 and status is 1 (bad select). Busy, irq_mask and erase_en never rise, and no erase pass is made.
- R2: A start with exactly one mask bit set raises erase_en in the next cycle, with no pre-write. While erase_en is high, erase_blk equals the accepted mask. Blocks outside that mask are never erased.
- R3: Each erase pass holds erase_en high for exactly erase_cycles consecutive cycles. A value of 0 is treated as 1.
- R4: The watchdog limit is WDOG_LIMIT = round(CLK_KHZ*19.8) cycles. A pulse of up to WDOG_LIMIT cycles completes normally. A longer one is cut off after WDOG_LIMIT cycles with erase_en low, and the operation ends with status 3 (watchdog abort) and no verify access.
- R5: Each verify read is preceded by a one-cycle dummy write (fl_wr) of 8'hFF. The address has bits [1:0] equal to 00 and lies inside the selected block.
- R6: In the cycle after the dummy write, fl_rd is asserted at the same address, and read data is taken one cycle after fl_rd. Within a pass the addresses run from block base = index*BLOCK_WORDS*4 upward in steps of 4. When all BLOCK_WORDS words read 32'hFFFFFFFF, the operation ends with status 0 (success).
- R7: The first word that reads other than all ones ends the pass and starts a new erase pass. When that happens on pass MAX_PASS (100), the operation ends with status 2 (retry exhausted), so at most MAX_PASS erase pulses are made.
- R8: irq_mask is high exactly when busy is high: from the cycle after acceptance through the last cycle of the operation. No erase, write or read strobe occurs without it.
- R9: done is a single-cycle pulse. status changes only in the cycle in which done is raised, and holds until the next start that is accepted or refused.
- R10: A start seen while busy is ignored. The running operation keeps its block, its pass count and its result.
- R11: While rst is high and after it, busy, done, irq_mask, erase_en, erase_blk, fl_wr and fl_rd are 0 and status is 0. This holds even when reset arrives mid-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| blk_mask | input | NUM_BLOCKS | Block-select mask, must be one-hot |
| erase_cycles | input | PULSE_W | Erase pulse length in clock cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | 0 success, 1 bad select, 2 retry exhausted, 3 watchdog abort |
| irq_mask | output | 1 | Masks all interrupts, including the non-maskable one |
| erase_en | output | 1 | Erase enable to the flash array |
| erase_blk | output | NUM_BLOCKS | Block being erased, zero when not erasing |
| fl_wr | output | 1 | Dummy verify write strobe |
| fl_rd | output | 1 | Verify read strobe |
| fl_addr | output | BLK_W+WOFF_W+2 | Byte address for the verify write and read |
| fl_wdata | output | 8 | Dummy write data (8'hFF during fl_wr) |
| fl_rdata | input | 32 | Verify read data, valid one cycle after fl_rd |

## Verification
The bench walks masks with no bit, one bit and several bits set. This separates the popcount check from a plain non-zero test and from a check of the lowest set bit alone. It drives a flash stub that needs one, three, exactly one hundred or two hundred erase passes before the block reads clean. These cases tell apart early success, normal retry, the last allowed pass and retry exhaustion. Pulse lengths of 0, small values, exactly the watchdog limit and one past it test the pulse width against the watchdog boundary. The stub flags any read that was not preceded by a matching FF write, or that breaks the step-by-4 order. Further directed cases cover a start while busy, reset during an erase, and status hold after done.

// File: rtl/ferase_pkg.sv
package ferase_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BADSEL = 2'd1,
    ST_RETRY  = 2'd2,
    ST_WDOG   = 2'd3
  } ferase_status_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ERASE = 3'd1,
    S_DWR   = 3'd2,
    S_RD    = 3'd3,
    S_CHK   = 3'd4
  } ferase_state_e;

  localparam logic [7:0]  DUMMY_BYTE  = 8'hFF;
  localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/ferase_sel_chk.sv
// Block-select validation: counts set bits and extracts the selected index.
module ferase_sel_chk #(
  parameter int NUM_BLOCKS = 4,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic [NUM_BLOCKS-1:0] mask,
  output logic                  one_hot,
  output logic [BLK_W-1:0]      idx
);

  always_comb begin
    int hits;
    hits = 0;
    idx  = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (mask[i]) begin
        hits = hits + 1;
        idx  = BLK_W'(i);
      end
    end
    one_hot = (hits == 1);
  end

endmodule

// File: rtl/ferase_timer.sv
// Erase pulse counter plus an independent watchdog counter.
module ferase_timer #(
  parameter int PULSE_W    = 16,
  parameter int WDOG_LIMIT = 198,
  localparam int WD_W = $clog2(WDOG_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PULSE_W-1:0] plen,
  output logic               pulse_done,
  output logic               wdog_hit
);

  logic [PULSE_W-1:0] pcnt_q;
  logic [WD_W-1:0]    wcnt_q;
  logic [PULSE_W-1:0] plen_eff;

  assign plen_eff   = (plen == '0) ? PULSE_W'(1) : plen;
  assign pulse_done = run && (pcnt_q == plen_eff - PULSE_W'(1));
  assign wdog_hit   = run && !pulse_done && (wcnt_q == WD_W'(WDOG_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + PULSE_W'(1);
      wcnt_q <= wcnt_q + WD_W'(1);
    end
  end

endmodule

// File: rtl/ferase_vaddr.sv
// Verify address generator: block index plus word offset, byte aligned.
module ferase_vaddr #(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_WORDS = 8,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int WOFF_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1,
  localparam int ADDR_W = BLK_W + WOFF_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BLK_W-1:0]  load_idx,
  input  logic              rewind,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  logic [BLK_W-1:0]  blk_q;
  logic [WOFF_W-1:0] woff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= '0;
      woff_q <= '0;
    end else if (load) begin
      blk_q  <= load_idx;
      woff_q <= '0;
    end else if (rewind) begin
      woff_q <= '0;
    end else if (step) begin
      woff_q <= woff_q + WOFF_W'(1);
    end
  end

  assign addr = {blk_q, woff_q, 2'b00};
  assign last = (woff_q == WOFF_W'(BLOCK_WORDS - 1));

endmodule

// File: rtl/ferase_seq.sv
module ferase_seq
  import ferase_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_WORDS = 8,
  parameter int PULSE_W     = 16,
  parameter int MAX_PASS    = 100,
  parameter int CLK_KHZ     = 250000,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int WOFF_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1,
  localparam int ADDR_W = BLK_W + WOFF_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_BLOCKS-1:0] blk_mask,
  input  logic [PULSE_W-1:0]    erase_cycles,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            status,
  output logic                  irq_mask,
  output logic                  erase_en,
  output logic [NUM_BLOCKS-1:0] erase_blk,
  output logic                  fl_wr,
  output logic                  fl_rd,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [7:0]            fl_wdata,
  input  logic [31:0]           fl_rdata
);

  // about 19.8 ms expressed in clock cycles, rounded
  localparam int WDOG_LIMIT = (CLK_KHZ * 198 + 5) / 10;
  localparam int PASS_W     = $clog2(MAX_PASS + 1);

  ferase_state_e         state_q, state_n;
  ferase_status_e        status_q, fin_code;
  logic                  sel_ok;
  logic [BLK_W-1:0]      sel_idx;
  logic                  idle, accept, reject, finish;
  logic                  pulse_done, wdog_hit;
  logic                  word_ok, last_word, pass_full;
  logic                  rewind, step;
  logic [PULSE_W-1:0]    plen_q;
  logic [NUM_BLOCKS-1:0] mask_q;
  logic [PASS_W-1:0]     pass_q;

  ferase_sel_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_sel (
    .mask    (blk_mask),
    .one_hot (sel_ok),
    .idx     (sel_idx)
  );

  ferase_timer #(.PULSE_W(PULSE_W), .WDOG_LIMIT(WDOG_LIMIT)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (state_q == S_ERASE),
    .plen       (plen_q),
    .pulse_done (pulse_done),
    .wdog_hit   (wdog_hit)
  );

  ferase_vaddr #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) u_vaddr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_idx (sel_idx),
    .rewind   (rewind),
    .step     (step),
    .addr     (fl_addr),
    .last     (last_word)
  );

  assign idle      = (state_q == S_IDLE);
  assign accept    = start && idle && sel_ok;
  assign reject    = start && idle && !sel_ok;
  assign word_ok   = (fl_rdata == ERASED_WORD);
  assign pass_full = (pass_q == PASS_W'(MAX_PASS));
  assign finish    = !idle && (state_n == S_IDLE);

  always_comb begin
    state_n  = state_q;
    fin_code = ST_OK;
    rewind   = 1'b0;
    step     = 1'b0;
    unique case (state_q)
      S_IDLE:  if (accept) state_n = S_ERASE;
      S_ERASE: begin
        if (pulse_done) begin
          state_n = S_DWR;
        end else if (wdog_hit) begin
          state_n  = S_IDLE;
          fin_code = ST_WDOG;
        end
      end
      S_DWR:   state_n = S_RD;
      S_RD:    state_n = S_CHK;
      S_CHK: begin
        if (!word_ok) begin
          if (pass_full) begin
            state_n  = S_IDLE;
            fin_code = ST_RETRY;
          end else begin
            state_n = S_ERASE;
            rewind  = 1'b1;
          end
        end else if (last_word) begin
          state_n = S_IDLE;
        end else begin
          state_n = S_DWR;
          step    = 1'b1;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      status_q  <= ST_OK;
      busy      <= 1'b0;
      irq_mask  <= 1'b0;
      done      <= 1'b0;
      erase_en  <= 1'b0;
      erase_blk <= '0;
      fl_wr     <= 1'b0;
      fl_rd     <= 1'b0;
      fl_wdata  <= '0;
      plen_q    <= '0;
      mask_q    <= '0;
      pass_q    <= '0;
    end else begin
      state_q   <= state_n;
      busy      <= (state_n != S_IDLE);
      irq_mask  <= (state_n != S_IDLE);
      erase_en  <= (state_n == S_ERASE);
      erase_blk <= (state_n == S_ERASE) ? (accept ? blk_mask : mask_q) : '0;
      fl_wr     <= (state_n == S_DWR);
      fl_rd     <= (state_n == S_RD);
      fl_wdata  <= (state_n == S_DWR) ? DUMMY_BYTE : 8'h00;
      done      <= reject || finish;
      if (reject) begin
        status_q <= ST_BADSEL;
      end else if (finish) begin
        status_q <= fin_code;
      end
      if (accept) begin
        plen_q <= erase_cycles;
        mask_q <= blk_mask;
        pass_q <= PASS_W'(1);
      end else if (rewind) begin
        pass_q <= pass_q + PASS_W'(1);
      end
    end
  end

  assign status = status_q;

endmodule

// File: rtl/ferase_seq_chk.sv
module ferase_seq_chk #(
  parameter int NUM_BLOCKS = 4,
  parameter int MAX_PASS   = 100,
  parameter int CLK_KHZ    = 250000,
  parameter int ADDR_W     = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [NUM_BLOCKS-1:0] blk_mask,
  input logic                  busy,
  input logic                  done,
  input logic [1:0]            status,
  input logic                  irq_mask,
  input logic                  erase_en,
  input logic [NUM_BLOCKS-1:0] erase_blk,
  input logic                  fl_wr,
  input logic                  fl_rd,
  input logic [ADDR_W-1:0]     fl_addr,
  input logic [7:0]            fl_wdata
);

  localparam int WDOG_LIMIT = (CLK_KHZ * 198 + 5) / 10;
  localparam int EW = $clog2(WDOG_LIMIT + 1);
  localparam int PW = $clog2(MAX_PASS + 2);

  logic [EW-1:0] ecnt_q;
  logic [PW-1:0] pcnt_q;
  logic          erase_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt_q  <= '0;
      pcnt_q  <= '0;
      erase_d <= 1'b0;
    end else begin
      erase_d <= erase_en;
      ecnt_q  <= erase_en ? ecnt_q + EW'(1) : '0;
      if (!busy) pcnt_q <= '0;
      else if (erase_en && !erase_d) pcnt_q <= pcnt_q + PW'(1);
    end
  end

  assert_bad_select_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && $countones(blk_mask) != 1) |=> (done && status == 2'd1 && !busy && !erase_en));

  assert_one_block_R2: assert property (@(posedge clk) disable iff (rst)
    erase_en |-> ($countones(erase_blk) == 1));

  assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    erase_en |-> (ecnt_q < EW'(WDOG_LIMIT)));

  assert_dummy_write_R5: assert property (@(posedge clk) disable iff (rst)
    fl_wr |-> (fl_wdata == 8'hFF && fl_addr[1:0] == 2'b00));

  assert_read_follows_write_R6: assert property (@(posedge clk) disable iff (rst)
    fl_rd |-> ($past(fl_wr) && $stable(fl_addr)));

  assert_pass_cap_R7: assert property (@(posedge clk) disable iff (rst)
    (erase_en && !erase_d) |-> (pcnt_q < PW'(MAX_PASS)));

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (rst)
    (busy || erase_en || fl_wr || fl_rd) |-> irq_mask);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(status));

endmodule

bind ferase_seq ferase_seq_chk #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .MAX_PASS   (MAX_PASS),
  .CLK_KHZ    (CLK_KHZ),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .blk_mask  (blk_mask),
  .busy      (busy),
  .done      (done),
  .status    (status),
  .irq_mask  (irq_mask),
  .erase_en  (erase_en),
  .erase_blk (erase_blk),
  .fl_wr     (fl_wr),
  .fl_rd     (fl_rd),
  .fl_addr   (fl_addr),
  .fl_wdata  (fl_wdata)
);

// File: tb/ferase_seq_bench.sv
`timescale 1ns/1ps
module ferase_seq_bench;

  localparam int NB     = 4;
  localparam int BW     = 8;
  localparam int PW     = 16;
  localparam int MAXP   = 100;
  localparam int KHZ    = 10;                    // scaled clock for a short watchdog
  localparam int WDL    = (KHZ * 198 + 5) / 10;  // 198 cycles
  localparam int AW     = 2 + 3 + 2;
  localparam int NWORDS = NB * BW;

  typedef struct packed {
    logic [3:0]  mask;
    logic [15:0] pulse;
    logic [7:0]  need;
    logic [1:0]  st;
    logic [7:0]  npass;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 16'd5,   8'd1,   2'd0, 8'd1},
    '{4'b0100, 16'd3,   8'd3,   2'd0, 8'd3},
    '{4'b0000, 16'd4,   8'd1,   2'd1, 8'd0},
    '{4'b0110, 16'd4,   8'd1,   2'd1, 8'd0},
    '{4'b1000, 16'd0,   8'd1,   2'd0, 8'd1},
    '{4'b0010, 16'd2,   8'd200, 2'd2, 8'd100},
    '{4'b0001, 16'd198, 8'd1,   2'd0, 8'd1},
    '{4'b0100, 16'd199, 8'd1,   2'd3, 8'd1},
    '{4'b1001, 16'd4,   8'd1,   2'd1, 8'd0},
    '{4'b0010, 16'd2,   8'd100, 2'd0, 8'd100},
    '{4'b1111, 16'd4,   8'd1,   2'd1, 8'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NB-1:0] blk_mask = '0;
  logic [PW-1:0] erase_cycles = '0;
  logic          busy, done, irq_mask, erase_en, fl_wr, fl_rd;
  logic [1:0]    status;
  logic [NB-1:0] erase_blk;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic [31:0]   fl_rdata = '0;

  always #2 clk = ~clk;

  ferase_seq #(
    .NUM_BLOCKS(NB), .BLOCK_WORDS(BW), .PULSE_W(PW), .MAX_PASS(MAXP), .CLK_KHZ(KHZ)
  ) u_ferase_seq (
    .clk(clk), .rst(rst), .start(start), .blk_mask(blk_mask), .erase_cycles(erase_cycles),
    .busy(busy), .done(done), .status(status), .irq_mask(irq_mask),
    .erase_en(erase_en), .erase_blk(erase_blk), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // flash stub and monitors
  logic [31:0]   mem [NWORDS];
  int            need_cur, op_idx;
  logic [NB-1:0] op_mask, blk_seen;
  int passes, width, wmin, wmax, reads_in_pass, wr_viol, addr_viol, irq_viol, blk_viol;
  int done_cnt, busy_cycles, exp_raddr;
  logic          erase_prev = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] last_wr;

  always @(posedge clk) if (fl_rd) fl_rdata <= mem[fl_addr >> 2];

  always @(negedge clk) begin
    if (erase_en && !erase_prev) begin
      passes++;
      width = 0;
      reads_in_pass = 0;
      exp_raddr = op_idx * BW * 4;
      blk_seen = erase_blk;
    end
    if (erase_en) begin
      width++;
      if (erase_blk != op_mask) blk_viol++;
    end
    if (!erase_en && erase_prev) begin
      if (width < wmin) wmin = width;
      if (width > wmax) wmax = width;
      if (need_cur > 0) need_cur--;
      if (need_cur == 0) begin
        for (int b = 0; b < NB; b++)
          if (blk_seen[b])
            for (int w = 0; w < BW; w++) mem[b*BW + w] = 32'hFFFF_FFFF;
      end
    end
    if (fl_wr) begin
      if (fl_wdata != 8'hFF || fl_addr[1:0] != 2'b00) wr_viol++;
      if (int'(fl_addr) / (BW*4) != op_idx) wr_viol++;
      last_wr = fl_addr;
      wr_valid = 1'b1;
    end
    if (fl_rd) begin
      if (!wr_valid || fl_addr != last_wr) wr_viol++;
      if (int'(fl_addr) != exp_raddr) addr_viol++;
      exp_raddr += 4;
      reads_in_pass++;
      wr_valid = 1'b0;
    end
    if (busy != irq_mask) irq_viol++;
    if ((erase_en || fl_wr || fl_rd) && !irq_mask) irq_viol++;
    if (busy) busy_cycles++;
    if (done) done_cnt++;
    erase_prev = erase_en;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [15:0] p, input int need,
                        input int intrude, output logic [1:0] st_o);
    int cyc;
    for (int i = 0; i < NWORDS; i++) mem[i] = 32'h0;
    need_cur = need;
    op_mask = m;
    op_idx = 0;
    for (int b = 0; b < NB; b++) if (m[b]) op_idx = b;
    passes = 0; wmin = 1000000; wmax = 0; reads_in_pass = 0;
    wr_viol = 0; addr_viol = 0; irq_viol = 0; blk_viol = 0; done_cnt = 0; busy_cycles = 0;
    blk_mask = m;
    erase_cycles = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 50000) begin
      if (cyc == intrude) begin
        start = 1'b1;
        blk_mask = 4'b0010;
      end else begin
        start = 1'b0;
        blk_mask = m;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) chk("R9", "done timeout", 0, 1);
    st_o = status;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] st;
    int exp_w;
    do_reset();
    // R11: reset state
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "done after reset", done, 0);
    chk("R11", "irq_mask after reset", irq_mask, 0);
    chk("R11", "erase_en after reset", erase_en, 0);
    chk("R11", "fl_wr/fl_rd after reset", int'(fl_wr) + int'(fl_rd), 0);
    chk("R11", "status after reset", status, 0);

    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].mask, VECS[v].pulse, int'(VECS[v].need), -1, st);
      chk(VECS[v].st == 2'd1 ? "R1" : (VECS[v].st == 2'd2 ? "R7" :
          (VECS[v].st == 2'd3 ? "R4" : "R6")), $sformatf("status vec%0d", v), st, VECS[v].st);
      chk("R7", $sformatf("erase passes vec%0d", v), passes, VECS[v].npass);
      chk("R9", $sformatf("done pulses vec%0d", v), done_cnt, 1);
      chk("R8", $sformatf("irq mask coverage vec%0d", v), irq_viol, 0);
      chk("R5", $sformatf("dummy write rule vec%0d", v), wr_viol, 0);
      if (VECS[v].st == 2'd1) begin
        chk("R1", $sformatf("busy cycles on reject vec%0d", v), busy_cycles, 0);
      end else begin
        exp_w = (VECS[v].pulse == 0) ? 1 : int'(VECS[v].pulse);
        if (exp_w > WDL) exp_w = WDL;
        chk(VECS[v].st == 2'd3 ? "R4" : "R3", $sformatf("min width vec%0d", v), wmin, exp_w);
        chk(VECS[v].st == 2'd3 ? "R4" : "R3", $sformatf("max width vec%0d", v), wmax, exp_w);
        chk("R2", $sformatf("erase block vec%0d", v), blk_viol, 0);
        chk("R6", $sformatf("address order vec%0d", v), addr_viol, 0);
        if (VECS[v].st == 2'd0)
          chk("R6", $sformatf("words read last pass vec%0d", v), reads_in_pass, BW);
        if (VECS[v].st == 2'd3)
          chk("R4", $sformatf("no verify after abort vec%0d", v), reads_in_pass, 0);
        begin
          int touched;
          touched = 0;
          for (int i = 0; i < NWORDS; i++)
            if (i / BW != op_idx && mem[i] != 32'h0) touched++;
          chk("R2", $sformatf("other blocks untouched vec%0d", v), touched, 0);
        end
      end
      if (v == 7) begin
        repeat (30) @(negedge clk);
        chk("R9", "status held after done", status, 3);
        chk("R9", "done stays low", done, 0);
      end
    end

    // R10: start while busy is ignored
    run_op(4'b0001, 16'd4, 2, 3, st);
    chk("R10", "status with intruding start", st, 0);
    chk("R10", "passes with intruding start", passes, 2);
    chk("R10", "block kept with intruding start", blk_viol, 0);
    chk("R10", "single done with intruding start", done_cnt, 1);

    // R11: reset in the middle of an erase pulse
    blk_mask = 4'b0100;
    erase_cycles = 16'd50;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2", "erase_en high mid pulse", erase_en, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R11", "erase_en under reset", erase_en, 0);
    chk("R11", "busy under reset", busy, 0);
    chk("R11", "irq_mask under reset", irq_mask, 0);
    chk("R11", "erase_blk under reset", erase_blk, 0);
    chk("R11", "status under reset", status, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", "idle after reset release", int'(busy) + int'(done) + int'(erase_en), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule